// File: doc/BRIEF.md
# Timer Interrupt Edge-to-Pending Bridge

This block sits between the per-CPU timer and watchdog interrupt lines and the private-interrupt inputs of an interrupt controller. Each source line is a level. The controller wants one "set pending" request per new event, so the bridge keeps the last sampled value of every line. It turns each low-to-high transition into exactly one request. A request names the target CPU and the private interrupt number.

There are two source lines per CPU. Source index `i` belongs to CPU `i >> 1`. An even index is that CPU's timer and an odd index is its watchdog. Rising edges are counted per source in small saturating backlog counters. A fixed-priority picker drains the backlogs through a single output register. Rises that happen in the same cycle, or while the controller stalls, are delivered later and are not lost. A stall from the controller freezes the presented request until it is taken.

Top module: `tmr_pend_bridge`

## Requirements
- R1: Synchronous active-high reset clears the stored previous levels to 0 and the backlogs to empty, and holds `pend_valid` low. A line that is high while reset is released therefore counts as a rising edge.
- R2: Each sampled transition of a source from a stored low to a current high produces exactly one accepted request, unless that source's backlog was full (see R8).
- R3: A falling edge, or a level that stays steady, produces no request. The stored previous level follows the input on every clock, whatever the direction of change.
- R4: The CPU field `pend_cpu` of a request from source `i` equals `i >> 1`.
- R5: The ID field `pend_id` of a request from source `i` equals 29 + (`i` & 1). Even sources (timers) give 29 and odd sources (watchdogs) give 30.
- R6: When several sources have pending rises, the lowest source index is presented first, and one request is granted per cycle at most.
- R7: While `pend_valid` and `pend_stall` are both high, the request stays valid and its fields do not change in the next cycle.
- R8: Each source buffers up to 2^CNT_W − 1 undelivered rises. Rises that arrive while its backlog is full are dropped.
- R9: On an idle bridge, a rise first sampled at clock edge k is presented with `pend_valid` high after clock edge k+1.
- R10: A request is accepted on a clock edge where `pend_valid` is high and `pend_stall` is low. If no backlog remains, `pend_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock; all inputs are synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | 2*NUM_CPU | Level interrupt lines; bit 2c is CPU c's timer, bit 2c+1 its watchdog |
| pend_stall | input | 1 | Controller cannot take the presented request this cycle |
| pend_valid | output | 1 | A set-pending request is presented |
| pend_cpu | output | 2 | Target CPU of the request |
| pend_id | output | 5 | Private interrupt number of the request |

## Verification
The bench targets several corner cases:
- A line that is already high when reset is released. A bridge that preloads its history would never report that line.
- A line held high for many cycles and then dropped. A bridge that treats levels as events would repeat the request or fire on the fall.
- All eight lines rising in one cycle. A single-slot design would lose all but one, and a wrong picker would present them out of order.
- Rises arriving during a long stall. A broken backlog would wrap or drop the held request, so the delivered count must be exactly the backlog limit plus the request already presented.
- A long run of random toggles and random stalls. This run compares the outputs on every cycle against a behavioural model and checks that deliveries balance rises.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CPU_W     = 2;
    localparam int ID_W      = 5;
    localparam int IRQ_TIMER = 29;
    localparam int IRQ_WDOG  = 30;

    typedef struct packed {
        logic [CPU_W-1:0] cpu;
        logic [ID_W-1:0]  id;
    } pend_req_t;

    // Source index bit 0 selects timer/watchdog; the upper bits name the CPU.
    function automatic pend_req_t src_to_req(input int unsigned idx);
        pend_req_t r;
        r.cpu = CPU_W'(idx >> 1);
        r.id  = ID_W'(IRQ_TIMER + int'(idx & 1));
        return r;
    endfunction
endpackage

// File: rtl/tpb_edge_detect.sv
module tpb_edge_detect #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] level,
    output logic [NSRC-1:0] rise
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [NSRC-1:0] hist_q;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            always_ff @(posedge clk) begin
                if (rst) hist_q[g] <= 1'b0;
                else     hist_q[g] <= level[g];
            end

            assign rise[g] = level[g] & ~hist_q[g];

            AST_NO_BACK_TO_BACK_RISE: assert property (@(posedge clk) disable iff (rst)
                rise[g] |=> !rise[g]); // R2
        end
    endgenerate
endmodule

// File: rtl/tpb_backlog.sv
module tpb_backlog #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic take,
    output logic busy
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        unique case ({rise, take})
            2'b10:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    AST_TAKE_NEEDS_WORK: assert property (@(posedge clk) disable iff (rst)
        take |-> cnt_q != '0); // R6
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && rise && !take) |=> cnt_q == CNT_MAX); // R8
    AST_GROWTH_NEEDS_RISE: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > $past(cnt_q)) |-> $past(rise)); // R3
endmodule

// File: rtl/tpb_arbiter.sv
module tpb_arbiter
    import tpb_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] busy,
    input  logic            stall,
    output logic [NSRC-1:0] take,
    output logic            valid,
    output pend_req_t       req
);
    timeunit 1ns;
    timeprecision 1ps;

    logic      valid_q;
    pend_req_t req_q;
    logic      load;
    logic      found;
    int        win;

    assign load = !valid_q || !stall;

    always_comb begin
        found = 1'b0;
        win   = 0;
        for (int i = 0; i < NSRC; i++) begin
            if (busy[i] && !found) begin
                found = 1'b1;
                win   = i;
            end
        end
        take = '0;
        if (load && found) take[win] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            req_q   <= '0;
        end else if (load) begin
            valid_q <= found;
            if (found) req_q <= src_to_req(unsigned'(win));
        end
    end

    assign valid = valid_q;
    assign req   = req_q;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid && stall) |=> (valid && $stable(req))); // R7
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take)); // R6
    AST_ID_LEGAL: assert property (@(posedge clk) disable iff (rst)
        valid |-> (int'(req.id) == IRQ_TIMER || int'(req.id) == IRQ_WDOG)); // R5
    AST_CPU_LEGAL: assert property (@(posedge clk) disable iff (rst)
        valid |-> int'(req.cpu) < NSRC / 2); // R4
endmodule

// File: rtl/tmr_pend_bridge.sv
module tmr_pend_bridge
    import tpb_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CNT_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2*NUM_CPU-1:0] src_level,
    input  logic                 pend_stall,
    output logic                 pend_valid,
    output logic [CPU_W-1:0]     pend_cpu,
    output logic [ID_W-1:0]      pend_id
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NSRC = 2 * NUM_CPU;

    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] busy;
    logic [NSRC-1:0] take;
    pend_req_t       req;

    tpb_edge_detect #(.NSRC(NSRC)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (src_level),
        .rise  (rise)
    );

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_bl
            tpb_backlog #(.CNT_W(CNT_W)) u_bl (
                .clk  (clk),
                .rst  (rst),
                .rise (rise[g]),
                .take (take[g]),
                .busy (busy[g])
            );
        end
    endgenerate

    tpb_arbiter #(.NSRC(NSRC)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .busy  (busy),
        .stall (pend_stall),
        .take  (take),
        .valid (pend_valid),
        .req   (req)
    );

    assign pend_cpu = req.cpu;
    assign pend_id  = req.id;

    AST_REQ_FROM_BACKLOG: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_valid) |-> $past(|busy)); // R2
    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && !pend_stall && !(|busy)) |=> !pend_valid); // R10
endmodule

// File: tb/tmr_pend_bridge_bench.sv
module tmr_pend_bridge_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NUM_CPU = 4;
    localparam int NSRC    = 2 * NUM_CPU;
    localparam int CNT_W   = 3;
    localparam int MAXC    = (1 << CNT_W) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_level = '0;
    logic            pend_stall = 1'b0;
    logic            pend_valid;
    logic [1:0]      pend_cpu;
    logic [4:0]      pend_id;

    tmr_pend_bridge #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) u_tmr_pend_bridge (
        .clk        (clk),
        .rst        (rst),
        .src_level  (src_level),
        .pend_stall (pend_stall),
        .pend_valid (pend_valid),
        .pend_cpu   (pend_cpu),
        .pend_id    (pend_id)
    );

    always #2.5 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    int  m_hist [NSRC];
    int  m_cnt  [NSRC];
    bit  m_ov;
    int  m_osrc;
    int  rises_total = 0;
    int  drops_total = 0;
    int  deliv [NSRC];
    bit  done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int out_src();
        return int'(pend_cpu) * 2 + (int'(pend_id) - 29);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NSRC; i++) begin
            m_hist[i] = 0;
            m_cnt[i]  = 0;
        end
        m_ov   = 1'b0;
        m_osrc = 0;
    endtask

    task automatic model_next(input logic [NSRC-1:0] l, input logic st);
        bit load;
        int win;
        load = !m_ov || !st;
        win  = -1;
        for (int i = 0; i < NSRC; i++)
            if (m_cnt[i] > 0 && win < 0) win = i;
        for (int i = 0; i < NSRC; i++) begin
            int r;
            int t;
            int c;
            r = (l[i] && m_hist[i] == 0) ? 1 : 0;
            t = (load && win == i) ? 1 : 0;
            rises_total += r;
            c = m_cnt[i] + r - t;
            if (c > MAXC) begin
                c = MAXC;
                drops_total++;
            end
            m_cnt[i]  = c;
            m_hist[i] = l[i] ? 1 : 0;
        end
        if (load) begin
            m_ov = (win >= 0);
            if (win >= 0) m_osrc = win;
        end
    endtask

    task automatic compare();
        check(pend_valid === m_ov, "R2", "valid", int'(pend_valid), int'(m_ov));
        if (m_ov && pend_valid) begin
            check(int'(pend_cpu) == (m_osrc >> 1), "R4", "cpu", int'(pend_cpu), m_osrc >> 1);
            check(int'(pend_id) == 29 + (m_osrc & 1), "R5", "id", int'(pend_id), 29 + (m_osrc & 1));
        end
    endtask

    task automatic step(input logic [NSRC-1:0] l, input logic st);
        if (pend_valid && !st) deliv[out_src()]++;
        src_level  = l;
        pend_stall = st;
        model_next(l, st);
        @(negedge clk);
        compare();
    endtask

    task automatic reset_seq(input logic [NSRC-1:0] l);
        rst        = 1'b1;
        src_level  = l;
        pend_stall = 1'b0;
        model_clear();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(pend_valid === 1'b0, "R1", "valid in reset", int'(pend_valid), 0);
        end
        rst = 1'b0;
    endtask

    function automatic int deliv_sum();
        int s = 0;
        for (int i = 0; i < NSRC; i++) s += deliv[i];
        return s;
    endfunction

    initial begin
        for (int i = 0; i < NSRC; i++) deliv[i] = 0;
        model_clear();
        @(negedge clk);

        // R1: source 3 high across reset release is seen as a rise
        reset_seq(8'h08);
        step(8'h08, 1'b0);
        check(pend_valid === 1'b0, "R9", "valid one edge after rise", int'(pend_valid), 0);
        step(8'h08, 1'b0);
        check(pend_valid === 1'b1 && out_src() == 3, "R1", "src after reset", out_src(), 3);
        step(8'h08, 1'b0);
        check(pend_valid === 1'b0, "R10", "valid after accept", int'(pend_valid), 0);

        // R3: steady high, then fall, produce nothing
        for (int k = 0; k < 6; k++) begin
            step(8'h08, 1'b0);
            check(pend_valid === 1'b0, "R3", "steady high", int'(pend_valid), 0);
        end
        for (int k = 0; k < 4; k++) begin
            step(8'h00, 1'b0);
            check(pend_valid === 1'b0, "R3", "after fall", int'(pend_valid), 0);
        end

        // R9: latency on idle bridge, source 4 (CPU 2 timer)
        step(8'h10, 1'b0);
        check(pend_valid === 1'b0, "R9", "valid after edge k", int'(pend_valid), 0);
        step(8'h10, 1'b0);
        check(pend_valid === 1'b1, "R9", "valid after edge k+1", int'(pend_valid), 1);
        check(int'(pend_cpu) == 2, "R4", "cpu of src4", int'(pend_cpu), 2);
        check(int'(pend_id) == 29, "R5", "id of src4", int'(pend_id), 29);
        step(8'h10, 1'b0);
        check(pend_valid === 1'b0, "R10", "single pulse", int'(pend_valid), 0);
        step(8'h00, 1'b0);

        // R6: all sources rise at once, delivered lowest index first
        step(8'hFF, 1'b0);
        for (int k = 0; k < NSRC; k++) begin
            step(8'hFF, 1'b0);
            check(pend_valid === 1'b1 && out_src() == k, "R6", "order", out_src(), k);
        end
        step(8'hFF, 1'b0);
        check(pend_valid === 1'b0, "R6", "drained", int'(pend_valid), 0);
        step(8'h00, 1'b0);
        step(8'h00, 1'b0);

        // R7: stalled request holds its value
        step(8'h02, 1'b1);
        step(8'h02, 1'b1);
        for (int k = 0; k < 4; k++) begin
            step(8'h02, 1'b1);
            check(pend_valid === 1'b1 && out_src() == 1, "R7", "held under stall", out_src(), 1);
        end
        step(8'h02, 1'b0);
        check(pend_valid === 1'b0, "R7", "released", int'(pend_valid), 0);
        step(8'h00, 1'b0);

        // R8: ten rises of source 0 under stall: 1 presented + MAXC buffered
        for (int i = 0; i < NSRC; i++) deliv[i] = 0;
        for (int k = 0; k < 10; k++) begin
            step(8'h01, 1'b1);
            step(8'h00, 1'b1);
        end
        for (int k = 0; k < 12; k++) step(8'h00, 1'b0);
        check(deliv[0] == 1 + MAXC, "R8", "delivered after saturation", deliv[0], 1 + MAXC);

        // R2: random toggles and stalls, deliveries balance rises
        begin
            int r0;
            int d0;
            int s0;
            r0 = rises_total;
            d0 = drops_total;
            s0 = deliv_sum();
            for (int k = 0; k < 3000; k++) begin
                logic [NSRC-1:0] m;
                for (int i = 0; i < NSRC; i++) m[i] = (($urandom % 16) == 0);
                step(src_level ^ m, (($urandom % 4) == 0));
            end
            for (int k = 0; k < 40; k++) step(src_level, 1'b0);
            check(deliv_sum() - s0 == (rises_total - r0) - (drops_total - d0), "R2",
                  "random deliveries", deliv_sum() - s0, (rises_total - r0) - (drops_total - d0));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired: got %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule